// File: doc/BRIEF.md
# UDP Destination Port Demultiplexer

This block sits behind a receive MAC and splits the incoming frame stream by UDP destination port. Frames arrive one 32-bit word per beat, with start and end markers, a valid signal and a ready signal. The first word carries two bytes of alignment padding ahead of the Ethernet destination address, so the EtherType falls in the low half of word 3. The IPv4 protocol byte falls in bits 23:16 of word 6, and the UDP destination port falls in the low half of word 9.

A small register file holds a table of stream-port entries and one control port number. When a frame is IPv4/UDP and its destination port matches an enabled entry, the whole frame goes to that entry's stream output. Every other frame goes to the control output: frames addressed to the control port, frames that match no entry, non-IPv4 or non-UDP frames, and frames too short to carry a UDP header. The block holds the first ten words of each frame until the destination port is known. It then replays them to the chosen output and passes the rest of the frame straight through.

All outputs share one data, start and end bus. Each output has its own valid and ready, and at most one valid is high at a time.

Top module: `udpdmx_top`

## Requirements
- R1: Entry k (k = 0 .. N_PORTS-1, which is 0 .. 2 by default) sits at register address k and holds the port number in bits 15:0 and an enable flag in bit 16. The control port number sits at address N_PORTS in bits 15:0. A read strobe returns the stored value on `reg_rdata` from the next cycle, with every unused bit zero.
- R2: The frame is routed whole to stream output k when all of these hold: EtherType (word 3, bits 15:0) is 0x0800, protocol (word 6, bits 23:16) is 17, the destination port (word 9, bits 15:0) equals an enabled entry k, and the port differs from the control port.
- R3: When several enabled entries hold the matching port, the lowest index wins.
- R4: An entry with bit 16 clear never matches. Frames that match no enabled entry go to the control output, index N_PORTS (3 by default).
- R5: Frames whose EtherType is not 0x0800 (for example ARP, 0x0806), or whose protocol is not 17 (for example ICMP, 1), go to the control output.
- R6: A frame that ends before word 9 (fewer than 10 words) goes to the control output unchanged.
- R7: A UDP frame whose destination port equals the control port goes to the control output, even when an enabled entry holds the same number.
- R8: Every frame leaves in its original word order with nothing added or lost. Start is set on its first output beat only, and end on its last output beat only.
- R9: At most one output valid is high in any cycle. Outputs other than the chosen one see no valid beats.
- R10: While the chosen output holds ready low with a beat pending, `in_ready` stays low. The pending beat is also held unchanged.
- R11: Input beats that arrive between frames without the start marker are dropped and reach no output.
- R12: After reset, `in_ready` is high, no output valid is high and every entry reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 17 | Write data: port in 15:0, enable in 16 |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_data | input | DATA_W | Input frame word |
| out_valid | output | N_PORTS+1 | Per-output valid; top index is the control output |
| out_ready | input | N_PORTS+1 | Per-output ready |
| out_sop | output | 1 | First beat of the frame on the shared bus |
| out_eop | output | 1 | Last beat of the frame on the shared bus |
| out_data | output | DATA_W | Shared output word |

## Verification
The bench aims at table priority. It uses duplicate entries, a disabled entry that shadows a later enabled one, and the control port placed inside the table. A design that scanned the table in the wrong order, or that ignored the enable bit or the control port, would send those frames to the wrong port. It also sends frames of exactly ten words, nine words and one word, where an off-by-one in the header count would route on stale fields or hang while waiting for a port word that never arrives. Junk beats without a start marker and random stalls with input gaps follow. A design that leaked the junk, lost a beat under backpressure, or let `in_ready` run ahead of a stalled output would show up as scoreboard mismatches.

// File: rtl/udpdmx_pkg.sv
// Shared constants and types for the UDP destination port demultiplexer.
// Assumes 32-bit frame words, with two bytes of alignment padding ahead of the MAC header.
package udpdmx_pkg;
    localparam int ENTRY_W    = 17;   // port number plus enable flag
    localparam int RDATA_W    = 32;
    localparam int HDR_WORDS  = 10;   // words held before the route decision
    localparam int ETYPE_WORD = 3;
    localparam int PROTO_WORD = 6;
    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [7:0]  PROTO_UDP  = 8'd17;

    typedef enum logic [1:0] {
        ST_COLLECT,
        ST_DRAIN,
        ST_PASS
    } dmx_state_t;
endpackage

// File: rtl/udpdmx_regs.sv
// Register file: N_PORTS entry registers (port in 15:0, enable in 16) at
// addresses 0..N_PORTS-1, and the control port at address N_PORTS.
// Reads are registered: data appears the cycle after the read strobe.
module udpdmx_regs
    import udpdmx_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int ADDR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [ENTRY_W-1:0]       reg_wdata,
    output logic [RDATA_W-1:0]       reg_rdata,
    output logic [N_PORTS-1:0][15:0] ent_port,
    output logic [N_PORTS-1:0]       ent_en,
    output logic [15:0]              ctrl_port
);
    logic [RDATA_W-1:0] rd_mux;

    for (genvar i = 0; i < N_PORTS; i++) begin : g_entry
        // Entry i: load port number and enable on a write to its address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_port[i] <= '0;
                ent_en[i]   <= 1'b0;
            end else if (reg_wr && reg_addr == ADDR_W'(i)) begin
                ent_port[i] <= reg_wdata[15:0];
                ent_en[i]   <= reg_wdata[16];
            end
        end
    end

    // Control port register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_port <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(N_PORTS))
            ctrl_port <= reg_wdata[15:0];
    end

    // Read selection by address, unused bits zero
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < N_PORTS; i++)
            if (reg_addr == ADDR_W'(i))
                rd_mux = {15'd0, ent_en[i], ent_port[i]};
        if (reg_addr == ADDR_W'(N_PORTS))
            rd_mux = {16'd0, ctrl_port};
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/udpdmx_match.sv
// Combinational route lookup. Returns the lowest enabled entry whose port
// equals the destination port for IPv4/UDP frames. Otherwise, or when the
// port equals the control port, it returns the control index N_PORTS.
module udpdmx_match
    import udpdmx_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int SEL_W   = 2
) (
    input  logic [15:0]              fld_etype,
    input  logic [7:0]               fld_proto,
    input  logic [15:0]              fld_dport,
    input  logic [N_PORTS-1:0][15:0] ent_port,
    input  logic [N_PORTS-1:0]       ent_en,
    input  logic [15:0]              ctrl_port,
    output logic [SEL_W-1:0]         match_sel
);
    logic is_udp;

    // Frame qualifies for table lookup
    always_comb is_udp = (fld_etype == ETYPE_IPV4) && (fld_proto == PROTO_UDP);

    // Priority scan: a downward loop leaves the lowest matching index
    always_comb begin
        match_sel = SEL_W'(N_PORTS);
        if (is_udp && fld_dport != ctrl_port)
            for (int i = N_PORTS - 1; i >= 0; i--)
                if (ent_en[i] && ent_port[i] == fld_dport)
                    match_sel = SEL_W'(i);
    end
endmodule

// File: rtl/udpdmx_core.sv
// Frame sequencer. It collects up to HDR_WORDS header words and samples the
// route from the matcher as the port word arrives. It then replays the held
// words to the chosen output and passes the rest of the frame through,
// with backpressure from that output only.
// Assumes the input holds a beat steady until it is accepted.
module udpdmx_core
    import udpdmx_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [DATA_W-1:0]  in_data,
    output logic [N_PORTS:0]   out_valid,
    input  logic [N_PORTS:0]   out_ready,
    output logic               out_sop,
    output logic               out_eop,
    output logic [DATA_W-1:0]  out_data,
    output logic [15:0]        fld_etype,
    output logic [7:0]         fld_proto,
    output logic [15:0]        fld_dport,
    input  logic [SEL_W-1:0]   match_sel
);
    localparam int CNT_W = $clog2(HDR_WORDS + 1);
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(N_PORTS);
    localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_WORDS - 1);

    dmx_state_t        state;
    logic [CNT_W-1:0]  cnt, rd_ptr, last_ptr;
    logic              hdr_eop;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] hbuf [HDR_WORDS];
    logic              take;

    // Beat is stored: collecting, and either inside a frame or at its start
    always_comb take = (state == ST_COLLECT) && in_valid && (cnt != '0 || in_sop);

    always_comb fld_dport = in_data[15:0];

    // Output steering and input ready per state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = '0;
        out_data  = in_data;
        out_sop   = 1'b0;
        out_eop   = 1'b0;
        case (state)
            ST_COLLECT: in_ready = 1'b1;
            ST_DRAIN: begin
                out_valid[sel_q] = 1'b1;
                out_data         = hbuf[rd_ptr];
                out_sop          = (rd_ptr == '0);
                out_eop          = (rd_ptr == last_ptr) && hdr_eop;
            end
            ST_PASS: begin
                out_valid[sel_q] = in_valid;
                in_ready         = out_ready[sel_q];
                out_eop          = in_eop;
            end
            default: ;
        endcase
    end

    // Header word storage
    always_ff @(posedge clk) begin
        if (take)
            hbuf[cnt] <= in_data;
    end

    // Sequencer state, field capture and route latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_COLLECT;
            cnt       <= '0;
            rd_ptr    <= '0;
            last_ptr  <= '0;
            hdr_eop   <= 1'b0;
            sel_q     <= SEL_CTRL;
            fld_etype <= '0;
            fld_proto <= '0;
        end else begin
            case (state)
                ST_COLLECT: if (take) begin
                    if (cnt == CNT_W'(ETYPE_WORD)) fld_etype <= in_data[15:0];
                    if (cnt == CNT_W'(PROTO_WORD)) fld_proto <= in_data[23:16];
                    if (in_eop || cnt == LAST_HDR) begin
                        sel_q    <= (cnt == LAST_HDR) ? match_sel : SEL_CTRL;
                        last_ptr <= cnt;
                        hdr_eop  <= in_eop;
                        rd_ptr   <= '0;
                        cnt      <= '0;
                        state    <= ST_DRAIN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRAIN: if (out_ready[sel_q]) begin
                    if (rd_ptr == last_ptr)
                        state <= hdr_eop ? ST_COLLECT : ST_PASS;
                    else
                        rd_ptr <= rd_ptr + 1'b1;
                end
                ST_PASS: if (in_valid && out_ready[sel_q] && in_eop)
                    state <= ST_COLLECT;
                default: state <= ST_COLLECT;
            endcase
        end
    end
endmodule

// File: rtl/udpdmx_top.sv
// UDP destination port demultiplexer top: register file, route matcher
// and frame sequencer. The top index of out_valid/out_ready is the control path.
module udpdmx_top
    import udpdmx_pkg::*;
#(
    parameter int N_PORTS = 3,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [ENTRY_W-1:0]   reg_wdata,
    output logic [RDATA_W-1:0]   reg_rdata,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sop,
    input  logic                 in_eop,
    input  logic [DATA_W-1:0]    in_data,
    output logic [N_PORTS:0]     out_valid,
    input  logic [N_PORTS:0]     out_ready,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic [DATA_W-1:0]    out_data
);
    localparam int N_OUT = N_PORTS + 1;
    localparam int SEL_W = $clog2(N_OUT);

    logic [N_PORTS-1:0][15:0] ent_port;
    logic [N_PORTS-1:0]       ent_en;
    logic [15:0]              ctrl_port;
    logic [15:0]              fld_etype, fld_dport;
    logic [7:0]               fld_proto;
    logic [SEL_W-1:0]         match_sel;

    udpdmx_regs #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ent_port(ent_port), .ent_en(ent_en), .ctrl_port(ctrl_port)
    );

    udpdmx_match #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_match (
        .fld_etype(fld_etype), .fld_proto(fld_proto), .fld_dport(fld_dport),
        .ent_port(ent_port), .ent_en(ent_en), .ctrl_port(ctrl_port),
        .match_sel(match_sel)
    );

    udpdmx_core #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_data(out_data),
        .fld_etype(fld_etype), .fld_proto(fld_proto), .fld_dport(fld_dport),
        .match_sel(match_sel)
    );
endmodule

// File: rtl/udpdmx_chk.sv
// Protocol checker for udpdmx_top, attached by bind.
module udpdmx_chk #(
    parameter int N_OUT  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [N_OUT-1:0]  out_valid,
    input logic [N_OUT-1:0]  out_ready,
    input logic              out_sop,
    input logic              out_eop,
    input logic [DATA_W-1:0] out_data,
    input logic [31:0]       reg_rdata
);
    logic acc, exp_sop;

    // Any output beat handed over this cycle
    always_comb acc = |(out_valid & out_ready);

    // Tracks whether the next accepted output beat starts a frame
    always_ff @(posedge clk) begin
        if (!rst_n)   exp_sop <= 1'b1;
        else if (acc) exp_sop <= out_eop;
    end

    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid)); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & ~out_ready)) |=> (out_valid == $past(out_valid)) && $stable(out_data)
            && $stable(out_sop) && $stable(out_eop)); // R10
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & ~out_ready)) |-> !in_ready); // R10
    AST_SOP_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> (out_sop == exp_sop)); // R8
    AST_RDATA_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:17] == '0); // R1
endmodule

bind udpdmx_top udpdmx_chk #(.N_OUT(N_PORTS + 1), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data), .reg_rdata(reg_rdata)
);

// File: tb/tb_udpdmx_top.sv
// Scoreboard bench: the frame driver pushes the expected beats, and the monitor pops and compares them.
module tb_udpdmx_top;
    localparam int N_PORTS = 3;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int N_OUT   = N_PORTS + 1;
    localparam int CTRL    = N_PORTS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0, reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [16:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic [N_OUT-1:0]  out_valid;
    logic [N_OUT-1:0]  out_ready = '1;
    logic              out_sop, out_eop;
    logic [DATA_W-1:0] out_data;

    always #5 clk = ~clk;  // 100 MHz

    udpdmx_top #(.N_PORTS(N_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
        .out_data(out_data)
    );

    typedef struct {
        int          port;
        logic [31:0] data;
        bit          sop;
        bit          eop;
        string       req;
    } beat_t;

    beat_t       sbq[$];
    logic [31:0] frm [0:63];
    logic [15:0] m_port [N_PORTS];
    bit          m_en [N_PORTS];
    logic [15:0] m_ctrl;
    int          n_checks = 0, n_fails = 0;
    bit          done = 1'b0, stall_en = 1'b0, gap_en = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Output stall pattern
    always @(posedge clk) begin
        #1;
        out_ready = stall_en ? N_OUT'($urandom) : '1;
    end

    // Monitor: compare every delivered beat with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N_OUT-1:0] acc;
            acc = out_valid & out_ready;
            if ($countones(out_valid) > 1)
                check(1'b0, "R9", "several outputs valid", 32'(out_valid), 32'd0);
            if (|(out_valid & ~out_ready))
                check(!in_ready, "R10", "in_ready while output stalled", 32'(in_ready), 32'd0);
            if (acc != '0) begin
                int idx = 0;
                for (int i = 0; i < N_OUT; i++) if (acc[i]) idx = i;
                if (sbq.size() == 0) begin
                    check(1'b0, "R11", "unexpected beat on output", 32'(idx), 32'hFFFF);
                end else begin
                    beat_t e;
                    e = sbq.pop_front();
                    check(idx == e.port, e.req, "output index", 32'(idx), 32'(e.port));
                    check(out_data == e.data, "R8", "beat data", out_data, e.data);
                    check(out_sop == e.sop && out_eop == e.eop, "R8", "sop/eop",
                          {30'd0, out_sop, out_eop}, {30'd0, e.sop, e.eop});
                end
            end
        end
    end

    task automatic reg_write(input int addr, input logic [16:0] val);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = ADDR_W'(addr); reg_wdata = val;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (addr < N_PORTS) begin
            m_port[addr] = val[15:0];
            m_en[addr]   = val[16];
        end else if (addr == N_PORTS) begin
            m_ctrl = val[15:0];
        end
    endtask

    task automatic reg_read(input int addr, output logic [31:0] val);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = ADDR_W'(addr);
        @(posedge clk); #1;
        reg_rd = 1'b0;
        @(negedge clk);
        val = reg_rdata;
    endtask

    // Reference route from the requirements
    function automatic int route(input logic [15:0] et, input logic [7:0] pr,
                                 input logic [15:0] dp, input int len);
        if (len < 10) return CTRL;
        if (et != 16'h0800 || pr != 8'd17) return CTRL;
        if (dp == m_ctrl) return CTRL;
        for (int i = 0; i < N_PORTS; i++)
            if (m_en[i] && m_port[i] == dp) return i;
        return CTRL;
    endfunction

    task automatic send_frame(input logic [15:0] et, input logic [7:0] pr,
                              input logic [15:0] dp, input int len,
                              input logic [7:0] seed, input string req);
        int p;
        for (int i = 0; i < len; i++) frm[i] = {seed, 8'(i), 16'hBE00 | 16'(i)};
        if (len > 3) frm[3] = {16'hA5A5, et};
        if (len > 6) frm[6] = {8'h40, pr, 16'h0000};
        if (len > 9) frm[9] = {16'd10, dp};
        p = route(et, pr, dp, len);
        for (int i = 0; i < len; i++) begin
            beat_t b;
            b.port = p; b.data = frm[i]; b.sop = (i == 0); b.eop = (i == len - 1); b.req = req;
            sbq.push_back(b);
        end
        @(posedge clk); #1;
        for (int i = 0; i < len; i++) begin
            if (gap_en && ($urandom % 4 == 0)) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1; in_data = frm[i];
            in_sop = (i == 0); in_eop = (i == len - 1);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    // R11: beats without a start marker between frames
    task automatic send_junk(input int n);
        @(posedge clk); #1;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == n - 1);
            in_data = 32'hDEAD0000 | 32'(i);
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_eop = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 3000 && sbq.size() != 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sbq.size() == 0, req, "beats still owed", 32'(sbq.size()), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
            report();
        end
    end

    initial begin
        logic [31:0] rv;
        for (int i = 0; i < N_PORTS; i++) begin m_port[i] = '0; m_en[i] = 1'b0; end
        m_ctrl = '0;

        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R12", "in_ready in reset", 32'(in_ready), 32'd1);
        check(out_valid == '0, "R12", "out_valid in reset", 32'(out_valid), 32'd0);
        @(posedge clk); #1; rst_n = 1'b1;
        for (int a = 0; a <= N_PORTS; a++) begin
            reg_read(a, rv);
            check(rv == 32'd0, "R12", "register after reset", rv, 32'd0);
        end

        // R1: program the table and read it back
        reg_write(0, 17'h10039);
        reg_write(1, 17'h1003A);
        reg_write(2, 17'h1003B);
        reg_write(3, 17'h0000B);
        reg_read(0, rv); check(rv == 32'h10039, "R1", "entry 0 readback", rv, 32'h10039);
        reg_read(1, rv); check(rv == 32'h1003A, "R1", "entry 1 readback", rv, 32'h1003A);
        reg_read(2, rv); check(rv == 32'h1003B, "R1", "entry 2 readback", rv, 32'h1003B);
        reg_read(3, rv); check(rv == 32'h0000B, "R1", "control port readback", rv, 32'h0000B);

        // R2: plain matches, including a frame of exactly ten words
        send_frame(16'h0800, 8'd17, 16'd58, 14, 8'h01, "R2");
        send_frame(16'h0800, 8'd17, 16'd59, 10, 8'h02, "R2");
        send_frame(16'h0800, 8'd17, 16'd57, 12, 8'h03, "R2");
        send_frame(16'h0800, 8'd17, 16'd1000, 12, 8'h04, "R4");
        drain("R2");

        // R7: control port, also when a table entry holds the same number
        send_frame(16'h0800, 8'd17, 16'd11, 11, 8'h05, "R7");
        reg_write(1, 17'h1000B);
        send_frame(16'h0800, 8'd17, 16'd11, 12, 8'h06, "R7");
        drain("R7");

        // R3: duplicate entries, lowest index wins
        reg_write(2, 17'h10039);
        send_frame(16'h0800, 8'd17, 16'd57, 13, 8'h07, "R3");
        drain("R3");

        // R4: disabled entry falls through to the next enabled one
        reg_write(0, 17'h00039);
        reg_read(0, rv); check(rv == 32'h00039, "R1", "disabled entry readback", rv, 32'h00039);
        send_frame(16'h0800, 8'd17, 16'd57, 12, 8'h08, "R4");
        drain("R4");

        // R5: non-UDP and non-IPv4 frames
        send_frame(16'h0800, 8'd1, 16'd57, 12, 8'h09, "R5");
        send_frame(16'h0806, 8'd17, 16'd57, 12, 8'h0A, "R5");
        drain("R5");

        // R6: short frames
        send_frame(16'h0800, 8'd17, 16'd57, 9, 8'h0B, "R6");
        send_frame(16'h0800, 8'd17, 16'd57, 6, 8'h0C, "R6");
        send_frame(16'h0800, 8'd17, 16'd57, 1, 8'h0D, "R6");
        drain("R6");

        // R11: junk without start marker, then a valid frame
        send_junk(3);
        send_frame(16'h0800, 8'd17, 16'd57, 12, 8'h0E, "R11");
        drain("R11");

        // R10 / R8: random stalls and input gaps
        stall_en = 1'b1; gap_en = 1'b1;
        for (int k = 0; k < 16; k++) begin
            logic [15:0] dp;
            dp = (k % 3 == 0) ? 16'd57 : (k % 3 == 1) ? 16'd11 : 16'd2000;
            send_frame(16'h0800, 8'd17, dp, 3 + (k * 7) % 25, 8'(8'h20 + k), "R10");
        end
        drain("R10");
        stall_en = 1'b0; gap_en = 1'b0;
        repeat (3) @(posedge clk);
        report();
    end
endmodule